// File: doc/BRIEF.md
# Audio Sample Unpacker with Channel Toggling

This block sits between a 32-bit audio data port and a serial audio line transmitter. Each word written to the port holds one sample. The block reads the word as a container of one to four bytes, in either byte order. It finds the sample at the low or the high end of that container, keeps the configured number of valid bits, and places the result at the top of a 24-bit output field.

In dual-channel mode, successive writes go to channel 1 and channel 2 in turn. The second write of each pair pushes one stereo entry into a small FIFO. In mono mode, each write is copied to both channels and pushed at once. The line side pops whole stereo entries. It sees occupancy, readiness and free-space information and two sticky error flags. A FIFO clear empties the queue and restarts the channel pairing. A soft reset does the same and also clears the error flags.

Top module: `audio_unpacker`

## Requirements
- R1: In mono mode (`stereo`=0) with `acc_mode`=1, each write pushes one entry that carries the same 24-bit sample on `ch1_out` and `ch2_out`.
- R2: With `big_end`=0 the byte at `wr_data[7:0]` is the least significant byte of the container. With `big_end`=1 it is the most significant byte, and the bytes that follow it in address order have falling weight.
- R3: With `msb_just`=0 the sample is the low `vbits` bits of the container. With `msb_just`=1 it is the high `vbits` bits of the container.
- R4: The kept sample is left-aligned into 24 bits, with zeros below it. If the sample is wider than 24 bits, its lowest bits are dropped. A `vbits` of 0, or a `vbits` larger than the container, is treated as the full container width.
- R5: The container is `bytes_m1`+1 bytes wide, taken from the low bytes of `wr_data`. The upper bytes of the word are ignored.
- R6: In dual-channel mode (`stereo`=1, `acc_mode`=1), the first write of a pair becomes channel 1 and the second becomes channel 2. Nothing is pushed until the second write arrives.
- R7: Writes with `acc_mode` other than 1 are ignored. They push nothing, raise no flag and do not advance the channel pairing.
- R8: The FIFO holds DEPTH (8) stereo entries and pops them in the order they were pushed. `fifo_empty`, `fifo_full` and `fifo_ready` (not full) track the occupancy. Both channel outputs read 0 while the FIFO is empty.
- R9: `chunk_ok` is 1 exactly when the number of free entries is at least `chunk_sz`.
- R10: A push attempted while the FIFO is full is dropped and sets the sticky flag `ovr_flag`.
- R11: A pop attempted while the FIFO is empty sets the sticky flag `udr_flag` and changes nothing else.
- R12: A `fifo_clr` pulse empties the FIFO and restarts the pairing at channel 1. Both sticky flags keep their values.
- R13: `sticky_ack` clears both sticky flags. A `soft_rst` pulse empties the FIFO, restarts the pairing and clears both sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| fifo_clr | input | 1 | FIFO clear pulse |
| sticky_ack | input | 1 | Clears the overflow and underrun flags |
| stereo | input | 1 | 0 mono, 1 dual channel |
| big_end | input | 1 | 0 little-endian, 1 big-endian container |
| msb_just | input | 1 | 0 sample at the low end, 1 sample at the high end |
| acc_mode | input | 2 | Access mode; only 1 (toggle) accepts writes |
| vbits | input | 6 | Valid bits per sample |
| bytes_m1 | input | 2 | Bytes per sample minus one |
| chunk_sz | input | 4 | Free entries required for `chunk_ok` |
| wr_en | input | 1 | Data word write strobe |
| wr_data | input | 32 | Written data word |
| rd_en | input | 1 | Pop strobe from the line side |
| ch1_out | output | 24 | Channel 1 sample at the FIFO head |
| ch2_out | output | 24 | Channel 2 sample at the FIFO head |
| fifo_ready | output | 1 | FIFO can accept an entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| chunk_ok | output | 1 | Enough free entries for one chunk |
| ovr_flag | output | 1 | Sticky overflow |
| udr_flag | output | 1 | Sticky underrun |

## Verification
The unpacking path is driven with words that have non-zero upper bytes and differing byte values. Such words show when the byte order was ignored, when the container was not masked or when the justification shift points the wrong way. Rows with 8, 16, 18, 20, 24 and 32 valid bits, together with a zero width and a too-large width, separate left-alignment from truncation and check the width clamp. In dual-channel mode, distinct values per write expose a swapped pairing or an early push. A fill past full, with a chunk threshold in the middle, followed by an ordered drain, distinguishes the occupancy flags from the dropped overflow entry.

// File: rtl/audio_unpacker.sv
module audio_unpacker #(
  parameter int DEPTH   = 8,
  parameter int OUT_W   = 24,
  parameter int CHUNK_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               fifo_clr,
  input  logic               sticky_ack,
  input  logic               stereo,
  input  logic               big_end,
  input  logic               msb_just,
  input  logic [1:0]         acc_mode,
  input  logic [5:0]         vbits,
  input  logic [1:0]         bytes_m1,
  input  logic [CHUNK_W-1:0] chunk_sz,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  output logic [OUT_W-1:0]   ch1_out,
  output logic [OUT_W-1:0]   ch2_out,
  output logic               fifo_ready,
  output logic               fifo_empty,
  output logic               fifo_full,
  output logic               chunk_ok,
  output logic               ovr_flag,
  output logic               udr_flag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 2 * OUT_W;

  logic [EW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             half;
  logic [OUT_W-1:0] hold;

  logic [5:0]  cbits, vb;
  logic [31:0] swp, cmask, vmask, cont, samp;
  logic [OUT_W-1:0] smp;

  assign cbits = ({4'd0, bytes_m1} + 6'd1) << 3;
  assign vb    = (vbits == 6'd0 || vbits > cbits) ? cbits : vbits;
  assign swp   = {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]};
  assign cmask = (cbits == 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << cbits) - 32'd1);
  assign vmask = (vb == 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << vb) - 32'd1);
  assign cont  = (big_end ? (swp >> (6'd32 - cbits)) : wr_data) & cmask;
  assign samp  = (msb_just ? (cont >> (cbits - vb)) : cont) & vmask;
  assign smp   = OUT_W'({samp, {OUT_W{1'b0}}} >> vb);

  logic take, push, do_push, do_pop, clr;
  logic [EW-1:0] entry;
  logic [CW-1:0] free_n;

  assign take       = wr_en && (acc_mode == 2'd1);
  assign push       = take && (!stereo || half);
  assign entry      = stereo ? {smp, hold} : {smp, smp};
  assign fifo_full  = (cnt == CW'(DEPTH));
  assign fifo_empty = (cnt == '0);
  assign fifo_ready = !fifo_full;
  assign do_push    = push && !fifo_full;
  assign do_pop     = rd_en && !fifo_empty;
  assign clr        = fifo_clr || soft_rst;
  assign free_n     = CW'(DEPTH) - cnt;
  assign chunk_ok   = ({{CHUNK_W{1'b0}}, free_n} >= {{CW{1'b0}}, chunk_sz});
  assign ch1_out    = fifo_empty ? '0 : mem[rp][OUT_W-1:0];
  assign ch2_out    = fifo_empty ? '0 : mem[rp][EW-1:OUT_W];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; half <= 1'b0; hold <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0; half <= 1'b0; hold <= '0;
    end else begin
      if (take) begin
        half <= stereo ? !half : 1'b0;
        if (stereo && !half) hold <= smp;
      end
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0; udr_flag <= 1'b0;
    end else if (soft_rst) begin
      ovr_flag <= 1'b0; udr_flag <= 1'b0;
    end else begin
      if (!fifo_clr && push && fifo_full) ovr_flag <= 1'b1;
      else if (sticky_ack)                ovr_flag <= 1'b0;
      if (!fifo_clr && rd_en && fifo_empty) udr_flag <= 1'b1;
      else if (sticky_ack)                  udr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_unpacker_chk.sv
module audio_unpacker_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             fifo_clr,
  input logic             sticky_ack,
  input logic [1:0]       acc_mode,
  input logic             wr_en,
  input logic             rd_en,
  input logic [OUT_W-1:0] ch1_out,
  input logic [OUT_W-1:0] ch2_out,
  input logic             fifo_ready,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             ovr_flag,
  input logic             udr_flag
);
  assert_full_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_empty);

  assert_ready_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready != fifo_full);

  assert_ignored_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_mode != 2'd1 && !rd_en && !fifo_clr && !soft_rst)
      |=> ($stable(fifo_empty) && $stable(ch1_out) && $stable(ch2_out)));

  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !sticky_ack && !soft_rst) |=> ovr_flag);

  assert_udr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_flag && !sticky_ack && !soft_rst) |=> udr_flag);

  assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr || soft_rst) |=> fifo_empty);

  assert_soft_rst_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!ovr_flag && !udr_flag));
endmodule

bind audio_unpacker audio_unpacker_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fifo_clr(fifo_clr),
  .sticky_ack(sticky_ack), .acc_mode(acc_mode), .wr_en(wr_en), .rd_en(rd_en),
  .ch1_out(ch1_out), .ch2_out(ch2_out), .fifo_ready(fifo_ready),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .ovr_flag(ovr_flag),
  .udr_flag(udr_flag)
);

// File: tb/test_audio_unpacker.sv
module test_audio_unpacker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, fifo_clr = 1'b0, sticky_ack = 1'b0;
  logic stereo = 1'b0, big_end = 1'b0, msb_just = 1'b0;
  logic [1:0] acc_mode = 2'd1;
  logic [5:0] vbits = 6'd16;
  logic [1:0] bytes_m1 = 2'd1;
  logic [3:0] chunk_sz = 4'd3;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [23:0] ch1_out, ch2_out;
  logic fifo_ready, fifo_empty, fifo_full, chunk_ok, ovr_flag, udr_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  audio_unpacker i_audio_unpacker (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fifo_clr(fifo_clr),
    .sticky_ack(sticky_ack), .stereo(stereo), .big_end(big_end),
    .msb_just(msb_just), .acc_mode(acc_mode), .vbits(vbits),
    .bytes_m1(bytes_m1), .chunk_sz(chunk_sz), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .ch1_out(ch1_out), .ch2_out(ch2_out),
    .fifo_ready(fifo_ready), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .chunk_ok(chunk_ok), .ovr_flag(ovr_flag), .udr_flag(udr_flag)
  );

  // {big_end, msb_just, vbits, bytes_m1, wr_data, expected 24-bit sample}
  localparam logic [65:0] VEC [12] = '{
    {1'b0, 1'b0, 6'd16, 2'd1, 32'hDEAD1234, 24'h123400},
    {1'b1, 1'b0, 6'd16, 2'd1, 32'hDEAD1234, 24'h341200},
    {1'b0, 1'b0, 6'd24, 2'd2, 32'hAB123456, 24'h123456},
    {1'b1, 1'b0, 6'd24, 2'd2, 32'hAB123456, 24'h563412},
    {1'b0, 1'b1, 6'd20, 2'd3, 32'h12345678, 24'h123450},
    {1'b0, 1'b0, 6'd20, 2'd3, 32'hFFF12345, 24'h123450},
    {1'b0, 1'b0, 6'd32, 2'd3, 32'h89ABCDEF, 24'h89ABCD},
    {1'b0, 1'b0, 6'd8,  2'd0, 32'h776655A5, 24'hA50000},
    {1'b0, 1'b1, 6'd18, 2'd2, 32'h00ABCDEF, 24'hABCDC0},
    {1'b1, 1'b1, 6'd16, 2'd3, 32'h11223344, 24'h443300},
    {1'b0, 1'b0, 6'd0,  2'd1, 32'h0000BEEF, 24'hBEEF00},
    {1'b0, 1'b0, 6'd30, 2'd1, 32'h1111CAFE, 24'hCAFE00}
  };

  function automatic string row_tag(input int i);
    case (i)
      1, 3:           return "R2";
      4, 8, 9:        return "R3";
      5, 6, 10, 11:   return "R4";
      default:        return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); sticky_ack = 1'b1;
    @(negedge clk); sticky_ack = 1'b0;
  endtask

  task automatic srst_pulse();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset empty", fifo_empty, 1);
    check("R8 reset full", fifo_full, 0);
    check("R8 reset ready", fifo_ready, 1);
    check("R8 reset ch1", ch1_out, 0);
    check("R10 reset ovr", ovr_flag, 0);
    check("R11 reset udr", udr_flag, 0);
    check("R9 reset chunk", chunk_ok, 1);

    // R1: mono table
    for (int i = 0; i < 12; i++) begin
      big_end = VEC[i][65]; msb_just = VEC[i][64]; vbits = VEC[i][63:58];
      bytes_m1 = VEC[i][57:56];
      wr(VEC[i][55:24]);
      check(row_tag(i), ch1_out, VEC[i][23:0]);
      check("R1 mono dup", ch2_out, VEC[i][23:0]);
      rd();
      check("R8 drained", fifo_empty, 1);
    end

    // R6: dual-channel pairing
    big_end = 0; msb_just = 0; vbits = 16; bytes_m1 = 1; stereo = 1;
    wr(32'h1111);
    check("R6 no push on first", fifo_empty, 1);
    wr(32'h2222);
    check("R6 ch1", ch1_out, 24'h111100);
    check("R6 ch2", ch2_out, 24'h222200);
    wr(32'h3333); wr(32'h4444);
    rd();
    check("R8 order ch1", ch1_out, 24'h333300);
    check("R8 order ch2", ch2_out, 24'h444400);
    rd();
    check("R8 empty after pops", fifo_empty, 1);

    // R9, R8, R10: fill past full
    chunk_sz = 3;
    for (int k = 0; k < 9; k++) begin
      wr(32'h1000 + k); wr(32'h2000 + k);
      if (k == 4) check("R9 free 3", chunk_ok, 1);
      if (k == 5) check("R9 free 2", chunk_ok, 0);
      if (k == 7) begin
        check("R8 full", fifo_full, 1);
        check("R8 not ready", fifo_ready, 0);
        check("R10 no ovr yet", ovr_flag, 0);
      end
    end
    check("R10 ovr set", ovr_flag, 1);
    check("R10 still full", fifo_full, 1);
    for (int k = 0; k < 8; k++) begin
      check("R10 kept entry ch1", ch1_out, (32'h1000 + k) << 8);
      check("R10 kept entry ch2", ch2_out, (32'h2000 + k) << 8);
      rd();
    end
    check("R10 dropped entry", fifo_empty, 1);

    // R11: underrun
    rd();
    check("R11 udr set", udr_flag, 1);
    check("R11 still empty", fifo_empty, 1);

    // R12: clear mid-pair
    wr(32'hAAAA);
    clr_pulse();
    wr(32'hBBBB); wr(32'hCCCC);
    check("R12 pairing restarted ch1", ch1_out, 24'hBBBB00);
    check("R12 pairing restarted ch2", ch2_out, 24'hCCCC00);
    check("R12 ovr kept", ovr_flag, 1);
    check("R12 udr kept", udr_flag, 1);
    clr_pulse();
    check("R12 emptied", fifo_empty, 1);

    // R13: acknowledge
    ack_pulse();
    check("R13 ack ovr", ovr_flag, 0);
    check("R13 ack udr", udr_flag, 0);

    // R7: other access modes ignored
    acc_mode = 2'd0; wr(32'h9999);
    acc_mode = 2'd2; wr(32'h8888);
    check("R7 nothing pushed", fifo_empty, 1);
    acc_mode = 2'd3; wr(32'h7777);
    check("R7 no flag", ovr_flag | udr_flag, 0);
    acc_mode = 2'd1;
    wr(32'h5555);
    check("R7 pairing not advanced", fifo_empty, 1);
    wr(32'h6666);
    check("R7 pair ch1", ch1_out, 24'h555500);
    check("R7 pair ch2", ch2_out, 24'h666600);

    // R13: soft reset
    rd(); rd();
    check("R13 udr before srst", udr_flag, 1);
    wr(32'h0101); wr(32'h0202); wr(32'h0303);
    srst_pulse();
    check("R13 srst empty", fifo_empty, 1);
    check("R13 srst udr", udr_flag, 0);
    wr(32'h0404);
    check("R13 srst pairing restarted", fifo_empty, 1);
    wr(32'h0505);
    check("R13 srst pair ch1", ch1_out, 24'h040400);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule